// File: doc/BRIEF.md
# Trimmed-Depth Synchronous FIFO

This block is a single-clock first-in first-out buffer whose capacity is 2^ADDR_W − 2^CUT_BIT words instead of a full power of two. With the default settings (ADDR_W = 4, CUT_BIT = 2) it holds 12 words, three quarters of what a 4-bit address could reach. The storage array holds exactly that many entries, so no memory is spent on unused words.

Both the read and the write pointer take a shortcut when they wrap. A pointer steps with an ordinary binary adder. On the one step where a plain rollover would leave the legal range, only bit CUT_BIT is corrected. A parameter selects the direction. Counting down, a pointer starts at depth − 1, and on the borrow out of zero bit CUT_BIT is cleared. Counting up, a pointer runs from 2^CUT_BIT to 2^ADDR_W − 1, and on the carry out of the top value bit CUT_BIT is set.

A separate occupancy counter drives the count output and all five status flags. The almost-full and almost-empty thresholds are parameters. Read data comes from a register.

Top module: `npfifo`

## Requirements
- R1: The FIFO holds exactly 2^ADDR_W − 2^CUT_BIT words (12 by default). `full` first asserts after that many accepted writes into an empty FIFO.
- R2: Words leave in the order they were accepted. This holds across any number of pointer wraps.
- R3: In down mode (DIR = DIR_DOWN, encoding 0), a pointer stays within 0 .. depth−1. When a pointer steps from 0, it reloads to depth−1.
- R4: In up mode (DIR = DIR_UP, encoding 1), a pointer stays within 2^CUT_BIT .. 2^ADDR_W−1. When a pointer steps from the all-ones value, it reloads to 2^CUT_BIT.
- R5: Down mode and up mode give identical values on every output for the same input sequence.
- R6: A write while `full` is ignored unless a read is accepted in the same cycle. A read while `empty` is ignored. An ignored access changes neither `count` nor `rd_data`, and an ignored write stores nothing.
- R7: A read and a write in the same cycle while not empty are both accepted and leave `count` unchanged. This includes the full case.
- R8: `count` equals the number of stored words and lies in the range 0 .. depth.
- R9: `full` is high exactly when count = depth. `empty` is high exactly when count = 0.
- R10: `almost_full` is high when count ≥ AFULL_LVL. `almost_empty` is high when count ≤ AEMPTY_LVL.
- R11: `half_full` is high when count ≥ depth/2.
- R12: `rd_data` is updated on the clock edge that accepts a read and holds its value in every other cycle.
- R13: A synchronous active-high `rst` clears `count` and `rd_data`, raises `empty`, and returns both pointers to their start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word read out |
| full | output | 1 | count = depth |
| empty | output | 1 | count = 0 |
| almost_full | output | 1 | count ≥ AFULL_LVL |
| almost_empty | output | 1 | count ≤ AEMPTY_LVL |
| half_full | output | 1 | count ≥ depth/2 |
| count | output | clog2(depth+1) | Stored word count |

## Verification
The hardest case to reach is the single wrap step: the borrow out of zero when counting down, or the carry out of all-ones when counting up. Each pointer takes it only once every depth accepted accesses, and only from a queue that keeps moving. The bench drives a long mixed run that swings between write-heavy and read-heavy phases, so both pointers pass the wrap many times, often while the FIFO is full or empty. Two instances, one per direction, run side by side against a single queue model.

// File: rtl/npfifo_pkg.sv
package npfifo_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } ptr_dir_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic afull;
        logic aempty;
        logic half;
    } occ_flags_t;

    function automatic int unsigned np_depth(int unsigned n, int unsigned m);
        return (32'd1 << n) - (32'd1 << m);
    endfunction

    function automatic int unsigned np_start(ptr_dir_e d, int unsigned n, int unsigned m);
        return (d == DIR_DOWN) ? np_depth(n, m) - 1 : (32'd1 << m);
    endfunction

endpackage

// File: rtl/npfifo_ptr.sv
module npfifo_ptr
    import npfifo_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned CUT_BIT = 2,
    parameter ptr_dir_e    DIR     = DIR_DOWN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] idx
);
    localparam logic [ADDR_W-1:0] START = ADDR_W'(np_start(DIR, ADDR_W, CUT_BIT));
    localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(32'd1 << CUT_BIT);

    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] nxt;
    logic              edge_bit;

    always_ff @(posedge clk) begin
        if (rst)       ptr <= START;
        else if (step) ptr <= nxt;
    end

    generate
        if (DIR == DIR_DOWN) begin : gen_down
            always_comb begin
                {edge_bit, raw} = {1'b0, ptr} - (ADDR_W+1)'(1);
                nxt = raw;
                if (edge_bit) nxt[CUT_BIT] = 1'b0;
            end
            assign idx = ptr;

            AST_DOWN_RANGE: assert property (@(posedge clk) disable iff (rst)
                ptr <= START); // R3
            AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
                (ptr == '0 && step) |=> ptr == START); // R3
        end else begin : gen_up
            always_comb begin
                {edge_bit, raw} = {1'b0, ptr} + (ADDR_W+1)'(1);
                nxt = raw;
                if (edge_bit) nxt[CUT_BIT] = 1'b1;
            end
            assign idx = ptr - BASE;

            AST_UP_RANGE: assert property (@(posedge clk) disable iff (rst)
                ptr >= START); // R4
            AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
                (ptr == '1 && step) |=> ptr == START); // R4
        end
    endgenerate

endmodule

// File: rtl/npfifo_occ.sv
module npfifo_occ
    import npfifo_pkg::*;
#(
    parameter int unsigned DEPTH      = 12,
    parameter int unsigned AFULL_LVL  = 10,
    parameter int unsigned AEMPTY_LVL = 2,
    localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             wr_ok,
    output logic             rd_ok,
    output logic [CNT_W-1:0] count,
    output occ_flags_t       flags
);
    always_comb begin
        flags.full   = (count == CNT_W'(DEPTH));
        flags.empty  = (count == '0);
        flags.afull  = (count >= CNT_W'(AFULL_LVL));
        flags.aempty = (count <= CNT_W'(AEMPTY_LVL));
        flags.half   = (count >= CNT_W'(DEPTH / 2));
    end

    assign rd_ok = rd_en && !flags.empty;
    assign wr_ok = wr_en && (!flags.full || rd_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (flags.full && wr_en && !rd_en) |=> $stable(count)); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && rd_en && !wr_en) |=> $stable(count)); // R6
    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !flags.empty) |=> $stable(count)); // R7
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flags.full && flags.empty)); // R9

endmodule

// File: rtl/npfifo_mem.sv
module npfifo_mem #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 12,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= store[ridx];
    end

    AST_WIDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        we |-> (32'(widx) < DEPTH)); // R1
    AST_RIDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        re |-> (32'(ridx) < DEPTH)); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata)); // R12

endmodule

// File: rtl/npfifo.sv
module npfifo
    import npfifo_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned CUT_BIT    = 2,
    parameter ptr_dir_e    DIR        = DIR_DOWN,
    parameter int unsigned AFULL_LVL  = 10,
    parameter int unsigned AEMPTY_LVL = 2,
    localparam int unsigned DEPTH     = np_depth(ADDR_W, CUT_BIT),
    localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              half_full,
    output logic [CNT_W-1:0]  count
);
    logic              wr_ok;
    logic              rd_ok;
    occ_flags_t        flags;
    logic [ADDR_W-1:0] widx;
    logic [ADDR_W-1:0] ridx;

    npfifo_occ #(
        .DEPTH      (DEPTH),
        .AFULL_LVL  (AFULL_LVL),
        .AEMPTY_LVL (AEMPTY_LVL)
    ) u_occ (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok),
        .count (count),
        .flags (flags)
    );

    npfifo_ptr #(.ADDR_W(ADDR_W), .CUT_BIT(CUT_BIT), .DIR(DIR)) u_wptr (
        .clk  (clk),
        .rst  (rst),
        .step (wr_ok),
        .idx  (widx)
    );

    npfifo_ptr #(.ADDR_W(ADDR_W), .CUT_BIT(CUT_BIT), .DIR(DIR)) u_rptr (
        .clk  (clk),
        .rst  (rst),
        .step (rd_ok),
        .idx  (ridx)
    );

    npfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok),
        .widx  (widx),
        .wdata (wr_data),
        .re    (rd_ok),
        .ridx  (ridx),
        .rdata (rd_data)
    );

    assign full         = flags.full;
    assign empty        = flags.empty;
    assign almost_full  = flags.afull;
    assign almost_empty = flags.aempty;
    assign half_full    = flags.half;

    AST_PTR_MATCH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        empty |-> (widx == ridx)); // R2
    AST_PTR_MATCH_FULL: assert property (@(posedge clk) disable iff (rst)
        full |-> (widx == ridx)); // R2

endmodule

// File: tb/sim_npfifo.sv
module sim_npfifo;
    import npfifo_pkg::*;

    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int CUT   = 2;
    localparam int DEPTH = 12;
    localparam int AF    = 10;
    localparam int AE    = 2;
    localparam int CW    = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;

    logic [DW-1:0] rd0, rd1;
    logic          f0, e0, af0, ae0, h0;
    logic          f1, e1, af1, ae1, h1;
    logic [CW-1:0] c0, c1;

    npfifo #(.DATA_W(DW), .ADDR_W(AW), .CUT_BIT(CUT), .DIR(DIR_DOWN),
             .AFULL_LVL(AF), .AEMPTY_LVL(AE)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd0), .full(f0), .empty(e0), .almost_full(af0),
        .almost_empty(ae0), .half_full(h0), .count(c0));

    npfifo #(.DATA_W(DW), .ADDR_W(AW), .CUT_BIT(CUT), .DIR(DIR_UP),
             .AFULL_LVL(AF), .AEMPTY_LVL(AE)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd1), .full(f1), .empty(e1), .almost_full(af1),
        .almost_empty(ae1), .half_full(h1), .count(c1));

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] exp_rd = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int n = q.size();
        chk("R8", "count u0", 32'(c0), n);
        chk("R5 R8", "count u1", 32'(c1), n);
        chk("R9", "full u0", 32'(f0), n == DEPTH);
        chk("R5 R9", "full u1", 32'(f1), n == DEPTH);
        chk("R9", "empty u0", 32'(e0), n == 0);
        chk("R5 R9", "empty u1", 32'(e1), n == 0);
        chk("R10", "almost_full u0", 32'(af0), n >= AF);
        chk("R5 R10", "almost_full u1", 32'(af1), n >= AF);
        chk("R10", "almost_empty u0", 32'(ae0), n <= AE);
        chk("R5 R10", "almost_empty u1", 32'(ae1), n <= AE);
        chk("R11", "half_full u0", 32'(h0), n >= DEPTH / 2);
        chk("R5 R11", "half_full u1", 32'(h1), n >= DEPTH / 2);
        chk("R2 R3 R12", "rd_data u0", 32'(rd0), 32'(exp_rd));
        chk("R2 R4 R5 R12", "rd_data u1", 32'(rd1), 32'(exp_rd));
    endtask

    // Drive one cycle just after a falling edge, update the model for the
    // coming rising edge, then compare at the next falling edge.
    task automatic cycle(bit w, bit r, logic [DW-1:0] d);
        bit wok, rok;
        wr_en   = w;
        rd_en   = r;
        wr_data = d;
        rok = r && (q.size() > 0);
        wok = w && ((q.size() < DEPTH) || r);
        if (rok) exp_rd = q.pop_front();
        if (wok) q.push_back(d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        q.delete();
        exp_rd = '0;
        rst = 1'b0;
        chk("R13", "count u0 after reset", 32'(c0), 0);
        chk("R13", "count u1 after reset", 32'(c1), 0);
        chk("R13", "empty u0 after reset", 32'(e0), 1);
        chk("R13", "empty u1 after reset", 32'(e1), 1);
        chk("R13", "rd_data u0 after reset", 32'(rd0), 0);
        chk("R13", "rd_data u1 after reset", 32'(rd1), 0);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: fill an empty FIFO; full only after exactly DEPTH writes
        for (int i = 0; i < DEPTH; i++) begin
            cycle(1'b1, 1'b0, 8'(i + 1));
            if (i == DEPTH - 2) chk("R1", "full one word short", 32'(f0), 0);
        end
        chk("R1", "full after depth writes", 32'(f0), 1);

        // R6: writes while full are dropped
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 8'hEE);
        chk("R6", "count held while full", 32'(c0), DEPTH);

        // R7: read and write together while full
        cycle(1'b1, 1'b1, 8'h55);
        chk("R7", "count after pair at full", 32'(c1), DEPTH);

        // drain past empty; R6 reads while empty leave rd_data alone
        for (int i = 0; i < DEPTH + 3; i++) cycle(1'b0, 1'b1, 8'h00);
        chk("R6", "rd_data held on empty read", 32'(rd0), 8'h55);

        // pair on empty: only the write is taken
        cycle(1'b1, 1'b1, 8'h77);
        chk("R6", "count after pair on empty", 32'(c0), 1);

        // long mixed traffic with shifting bias wraps both pointers (R3, R4)
        for (int blk = 0; blk < 30; blk++) begin
            int wp = (blk % 3 == 0) ? 80 : ((blk % 3 == 1) ? 20 : 50);
            if (blk == 15) do_reset();
            for (int k = 0; k < 100; k++) begin
                bit w = ($urandom_range(99) < wp);
                bit r = ($urandom_range(99) < (100 - wp));
                cycle(w, r, 8'($urandom_range(255)));
            end
        end

        wr_en = 1'b0;
        rd_en = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule